// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block accepts word writes and reads from a simple 32-bit bus and drives a small behavioural flash-like array. Operations are started only by fixed multi-write command sequences: a three-write sequence arms a page program, and a six-write sequence starts a chip erase. Once a page program is armed, the controller collects exactly one page of word data in address order. It then runs a timed program phase that can only clear bits. Chip erase sets every word of every unprotected block to all-ones.

A per-block protection mask keeps program and erase away from chosen blocks. While an operation is armed or running, the ready flag is low, reads return a status word instead of array data, and new command writes are discarded. A fault-injection input makes the running operation fail. The controller then stays locked with the ready flag low until the hardware reset. The behavioural array comes out of hardware reset fully erased.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `rdy` is 1, `locked` is 0 and every array word reads 0xFFFFFFFF.
- R2: A command sequence starts with a write of 0x000000AA to key address A (0x54), followed by a write of 0x00000055 to key address B (0x28). Any write that does not match the expected step returns the decoder to read mode without starting anything.
- R3: A third write of 0x000000A0 to key address A arms a page program. `rdy` drops to 0 at once. While `rdy` is 0, a read returns the status word {30'b0, locked, 1'b0} one cycle later.
- R4: Page data must arrive as aligned words (byte address bits [1:0] = 0). The first word goes to the page's first word, and each later word goes to the next word of that same page. A data write that is unaligned, out of order, or aimed at a different page is ignored.
- R5: Programming always covers the whole page. The new content of each word is the old value AND the supplied data.
- R6: `rdy` returns to 1 exactly PROG_CYCLES clock edges after the edge that accepts the last page word.
- R7: While a program or erase is armed or running, writes that would form a new command sequence have no effect.
- R8: A page program aimed at a protected block (bit b of `prot` protects block b) leaves that block unchanged.
- R9: The erase sequence is the first two unlock writes, then 0x80 to A, 0xAA to A, 0x55 to B and 0x10 to A. It starts on the sixth write. After ERASE_CYCLES edges, `rdy` is 1, every word of each unprotected block is 0xFFFFFFFF, and protected blocks are unchanged.
- R10: If every block is protected, the erase sequence changes nothing and `rdy` stays 1.
- R11: If `fault_inj` is high during a program or erase run, the array is left untouched and `locked` becomes 1 with `rdy` at 0. The controller ignores all writes until `rst_n` is asserted.
- R12: A write of 0x000000F0 during the unlock steps aborts the sequence. During page data entry, 0x000000F0 is stored as ordinary data.
- R13: In read mode, a read returns the addressed array word one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| prot | input | NUM_BLOCKS | Per-block protection mask |
| fault_inj | input | 1 | Forces the running operation to fail |
| rdy | output | 1 | 1 in read mode, 0 while armed, running or locked |
| locked | output | 1 | Failure lockout |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that `prot` does not change while an operation is armed or running. The bench drives one strobe per transaction and changes `prot` only while `rdy` is 1. `fault_inj` is raised only during a run the bench means to fail, and it is held until the lockout is observed. The key addresses are assumed to lie inside the array address range, which the default geometry satisfies.

// File: rtl/fcc_pkg.sv
// Shared types and command codes for the flash command controller.
// Assumes 32-bit bus data; codes are compared against the full word.
package fcc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_U1, ST_U2, ST_PLOAD, ST_PRUN,
        ST_E3, ST_E4, ST_E5, ST_ERUN, ST_LOCK
    } fcc_state_t;

    localparam logic [31:0] KEY_D1     = 32'h0000_00AA;
    localparam logic [31:0] KEY_D2     = 32'h0000_0055;
    localparam logic [31:0] CODE_PROG  = 32'h0000_00A0;
    localparam logic [31:0] CODE_ERASE = 32'h0000_0080;
    localparam logic [31:0] CODE_CHIP  = 32'h0000_0010;
endpackage

// File: rtl/fcc_timer.sv
// Down-counter that models the duration of a program or erase run.
// Assumes the loaded value is at least 2; done pulses for one cycle
// so the run ends exactly load_val edges after the load edge.
module fcc_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == CW'(1));
endmodule

// File: rtl/fcc_array.sv
// Behavioural cell array plus one-page write buffer.
// Assumes prog_go and erase_go are single-cycle and never together.
// Program ANDs the buffer into one page; erase sets words to ones;
// both skip blocks whose protect bit is set.
module fcc_array #(
    parameter int PAGE_WORDS      = 4,
    parameter int PAGES_PER_BLOCK = 2,
    parameter int NUM_BLOCKS      = 4,
    localparam int PAGES = PAGES_PER_BLOCK * NUM_BLOCKS,
    localparam int WORDS = PAGES * PAGE_WORDS,
    localparam int WPB   = PAGE_WORDS * PAGES_PER_BLOCK,
    localparam int WA    = $clog2(WORDS),
    localparam int PIW   = $clog2(PAGE_WORDS),
    localparam int PGW   = $clog2(PAGES),
    localparam int BW    = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  buf_we,
    input  logic [PIW-1:0]        buf_idx,
    input  logic [31:0]           buf_data,
    input  logic                  prog_go,
    input  logic [PGW-1:0]        prog_page,
    input  logic                  erase_go,
    input  logic [NUM_BLOCKS-1:0] prot,
    input  logic [WA-1:0]         rd_word,
    output logic [31:0]           rd_data
);
    logic [31:0] pbuf [PAGE_WORDS];
    logic [31:0] mem  [WORDS];

    // Capture page data words as the sequencer accepts them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= '1;
        end else if (buf_we) begin
            pbuf[buf_idx] <= buf_data;
        end
    end

    // Apply erase or page program to unprotected words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '1;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (!prot[BW'(w / WPB)]) begin
                    if (erase_go)
                        mem[w] <= '1;
                    else if (prog_go && prog_page == PGW'(w / PAGE_WORDS))
                        mem[w] <= mem[w] & pbuf[PIW'(w % PAGE_WORDS)];
                end
            end
        end
    end

    assign rd_data = mem[rd_word];
endmodule

// File: rtl/fcc_seq.sv
// Command sequence decoder and operation state machine.
// Assumes byte addresses with word data; key addresses lie within
// ADDR_W bits. Once page data entry starts, every write is treated as
// data, so abort codes have no effect there.
module fcc_seq
    import fcc_pkg::*;
#(
    parameter int PAGE_WORDS   = 4,
    parameter int PAGES        = 8,
    parameter int ADDR_W       = 7,
    parameter int CW           = 5,
    parameter int PROG_CYCLES  = 6,
    parameter int ERASE_CYCLES = 24,
    parameter logic [ADDR_W-1:0] KEY_A = 'h54,
    parameter logic [ADDR_W-1:0] KEY_B = 'h28,
    localparam int PIW = $clog2(PAGE_WORDS),
    localparam int PGW = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              all_prot,
    input  logic              fault_inj,
    input  logic              t_done,
    output fcc_state_t        state,
    output logic              buf_we,
    output logic [PIW-1:0]    buf_idx,
    output logic              prog_go,
    output logic [PGW-1:0]    prog_page,
    output logic              erase_go,
    output logic              t_load,
    output logic [CW-1:0]     t_val
);
    fcc_state_t     nxt;
    logic [PIW-1:0] idx_q;
    logic [PGW-1:0] page_q;
    logic           fault_q;
    logic           at_a, key1, key2, accept, last, chip_go, fail;
    logic [PIW-1:0] off;
    logic [PGW-1:0] pg;

    assign off = addr[PIW+1:2];
    assign pg  = addr[ADDR_W-1:PIW+2];

    // Decode key matches, page data acceptance and run completion.
    always_comb begin
        at_a    = wr_en && (addr == KEY_A);
        key1    = at_a && (wdata == KEY_D1);
        key2    = wr_en && (addr == KEY_B) && (wdata == KEY_D2);
        accept  = (state == ST_PLOAD) && wr_en && (addr[1:0] == 2'b00) &&
                  (off == idx_q) && ((idx_q == '0) || (pg == page_q));
        last    = accept && (idx_q == PIW'(PAGE_WORDS - 1));
        chip_go = (state == ST_E5) && at_a && (wdata == CODE_CHIP) && !all_prot;
        t_load  = last || chip_go;
        t_val   = last ? CW'(PROG_CYCLES) : CW'(ERASE_CYCLES);
        fail    = fault_q || fault_inj;
        prog_go  = (state == ST_PRUN) && t_done && !fail;
        erase_go = (state == ST_ERUN) && t_done && !fail;
    end

    // Next-state selection for unlock, data entry, run and lockout.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (key1) nxt = ST_U1;
            ST_U1:    if (wr_en) nxt = key2 ? ST_U2 : ST_IDLE;
            ST_U2:    if (wr_en) begin
                          if (at_a && wdata == CODE_PROG)       nxt = ST_PLOAD;
                          else if (at_a && wdata == CODE_ERASE) nxt = ST_E3;
                          else                                  nxt = ST_IDLE;
                      end
            ST_PLOAD: if (last) nxt = ST_PRUN;
            ST_E3:    if (wr_en) nxt = key1 ? ST_E4 : ST_IDLE;
            ST_E4:    if (wr_en) nxt = key2 ? ST_E5 : ST_IDLE;
            ST_E5:    if (wr_en) nxt = chip_go ? ST_ERUN : ST_IDLE;
            ST_PRUN,
            ST_ERUN:  if (t_done) nxt = fail ? ST_LOCK : ST_IDLE;
            ST_LOCK:  nxt = ST_LOCK;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State, page word index, target page and sticky fault registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx_q   <= '0;
            page_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state != ST_PLOAD) idx_q <= '0;
            else if (accept)       idx_q <= idx_q + 1'b1;
            if (accept && idx_q == '0) page_q <= pg;
            if (t_load)
                fault_q <= 1'b0;
            else if ((state == ST_PRUN || state == ST_ERUN) && fault_inj)
                fault_q <= 1'b1;
        end
    end

    assign buf_we    = accept;
    assign buf_idx   = idx_q;
    assign prog_page = page_q;
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command controller: decoder, run timer and array.
// Assumes rd_en and wr_en are not high together and prot is steady
// while an operation is armed or running. rdata is registered.
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int PAGE_WORDS      = 4,
    parameter int PAGES_PER_BLOCK = 2,
    parameter int NUM_BLOCKS      = 4,
    parameter int PROG_CYCLES     = 6,
    parameter int ERASE_CYCLES    = 24,
    localparam int PAGES  = PAGES_PER_BLOCK * NUM_BLOCKS,
    localparam int WORDS  = PAGES * PAGE_WORDS,
    localparam int WA     = $clog2(WORDS),
    localparam int ADDR_W = WA + 2,
    localparam int PIW    = $clog2(PAGE_WORDS),
    localparam int PGW    = $clog2(PAGES),
    localparam int CW     = $clog2((PROG_CYCLES > ERASE_CYCLES ?
                                    PROG_CYCLES : ERASE_CYCLES) + 1),
    parameter logic [ADDR_W-1:0] KEY_A = 'h54,
    parameter logic [ADDR_W-1:0] KEY_B = 'h28
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  logic [NUM_BLOCKS-1:0] prot,
    input  logic                  fault_inj,
    output logic                  rdy,
    output logic                  locked
);
    fcc_state_t     st;
    logic           buf_we, prog_go, erase_go, t_load, t_done;
    logic [PIW-1:0] buf_idx;
    logic [PGW-1:0] prog_page;
    logic [CW-1:0]  t_val;
    logic [31:0]    arr_rd;

    fcc_seq #(
        .PAGE_WORDS(PAGE_WORDS), .PAGES(PAGES), .ADDR_W(ADDR_W), .CW(CW),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
        .KEY_A(KEY_A), .KEY_B(KEY_B)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .all_prot(&prot), .fault_inj(fault_inj), .t_done(t_done),
        .state(st), .buf_we(buf_we), .buf_idx(buf_idx), .prog_go(prog_go),
        .prog_page(prog_page), .erase_go(erase_go), .t_load(t_load),
        .t_val(t_val)
    );

    fcc_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
    );

    fcc_array #(
        .PAGE_WORDS(PAGE_WORDS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .NUM_BLOCKS(NUM_BLOCKS)
    ) u_arr (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_data(wdata), .prog_go(prog_go), .prog_page(prog_page),
        .erase_go(erase_go), .prot(prot), .rd_word(addr[ADDR_W-1:2]),
        .rd_data(arr_rd)
    );

    assign rdy    = (st == ST_IDLE) || (st == ST_U1) || (st == ST_U2) ||
                    (st == ST_E3) || (st == ST_E4) || (st == ST_E5);
    assign locked = (st == ST_LOCK);

    // Registered read port: array word in read mode, status otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rdy ? arr_rd : {30'd0, locked, 1'b0};
    end
endmodule

// File: rtl/fcc_checker.sv
// Property checker for flash_cmd_ctrl, attached by bind.
// Assumes the same port conventions as the top module.
module fcc_checker
    import fcc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic        rdy,
    input logic        locked,
    input logic [31:0] rdata,
    input fcc_state_t  state
);
    // R11: the lockout never clears without a reset
    a_r11_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R11: a locked controller never reports ready
    a_r11_lock_busy: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !rdy);

    // R3: a read while busy returns the status word
    a_r3_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rdy) |=> (rdata == {30'd0, $past(locked), 1'b0}));

    // R7: a program run leaves only by completion or failure
    a_r7_prun_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRUN) |=> (state inside {ST_PRUN, ST_IDLE, ST_LOCK}));

    // R7: an erase run leaves only by completion or failure
    a_r7_erun_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERUN) |=> (state inside {ST_ERUN, ST_IDLE, ST_LOCK}));

    // R3: armed data entry keeps ready low
    a_r3_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLOAD) |-> !rdy);
endmodule

bind flash_cmd_ctrl fcc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rdy(rdy),
    .locked(locked), .rdata(rdata), .state(st)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
    localparam int PW = 4, PPB = 2, NB = 4, PC = 6, EC = 24;
    localparam int PAGES = PW * 0 + PPB * NB;
    localparam int WORDS = PAGES * PW;
    localparam int AW = $clog2(WORDS) + 2;
    localparam logic [AW-1:0] KA = 'h54, KB = 'h28;

    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, fault_inj = 0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [NB-1:0] prot = '0;
    logic rdy, locked;
    logic [31:0] model [WORDS];
    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.PAGE_WORDS(PW), .PAGES_PER_BLOCK(PPB), .NUM_BLOCKS(NB),
        .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .KEY_A(KA), .KEY_B(KB)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .prot(prot), .fault_inj(fault_inj),
        .rdy(rdy), .locked(locked));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] wa(int p, int w);
        return AW'((p * PW + w) * 4);
    endfunction

    function automatic logic [31:0] pat(int s, int p, int w);
        return 32'(s * 32'h0103_0507) ^ 32'((p * PW + w) * 32'h0011_2233) ^ 32'h0F0F_F0F0;
    endfunction

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!rdy && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic unlock_prog();
        wr(KA, 32'hAA); wr(KB, 32'h55); wr(KA, 32'hA0);
    endtask

    task automatic unlock_erase();
        wr(KA, 32'hAA); wr(KB, 32'h55); wr(KA, 32'h80);
        wr(KA, 32'hAA); wr(KB, 32'h55); wr(KA, 32'h10);
    endtask

    task automatic model_reset();
        for (int i = 0; i < WORDS; i++) model[i] = '1;
    endtask

    // s < 0 programs every word with 0x000000F0
    task automatic prog_page(int p, int s, bit chk_time);
        int n;
        logic [31:0] d;
        unlock_prog();
        check("R3 armed busy", {31'd0, rdy}, 0);
        for (int w = 0; w < PW; w++) begin
            d = (s < 0) ? 32'hF0 : pat(s, p, w);
            wr(wa(p, w), d);
            if (!prot[(p * PW + w) / (PW * PPB)]) model[p * PW + w] &= d;
        end
        wait_rdy(n);
        if (chk_time) check("R6 program duration", n, PC);
    endtask

    task automatic erase_all();
        int n;
        unlock_erase();
        if (&prot) check("R10 no busy when all protected", {31'd0, rdy}, 1);
        else begin
            wait_rdy(n);
            check("R9 erase duration", n, EC);
        end
        for (int i = 0; i < WORDS; i++)
            if (!prot[i / (PW * PPB)]) model[i] = '1;
    endtask

    task automatic verify_all(string req);
        logic [31:0] d;
        for (int i = 0; i < WORDS; i++) begin
            rd(AW'(i * 4), d);
            check(req, d, model[i]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; fault_inj = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, rdy}, 1);
        check("R1 unlocked after reset", {31'd0, locked}, 0);
        verify_all("R1 R13 erased array");

        // R3: status read while armed, then full sweep of page programs
        unlock_prog();
        rd(0, d);
        check("R3 status word while armed", d, 32'h0);
        for (int w = 0; w < PW; w++) begin
            wr(wa(0, w), pat(1, 0, w)); model[w] &= pat(1, 0, w);
        end
        wait_rdy(n);
        check("R6 program duration", n, PC);
        for (int p = 1; p < PAGES; p++) prog_page(p, 1, 1);
        verify_all("R5 R13 first pattern");
        for (int p = 0; p < PAGES; p++) prog_page(p, 2, 1);
        verify_all("R5 AND with second pattern");

        // R4: misplaced data words are ignored
        unlock_prog();
        wr(wa(3, 2), 32'h0);
        wr(wa(3, 0) + 1, 32'h0);
        wr(wa(3, 0), 32'h1234_5678);
        wr(wa(4, 1), 32'h0);
        wr(wa(3, 2), 32'h0);
        wr(wa(3, 1), 32'hFFFF_0000);
        wr(wa(3, 2), 32'h00FF_FF00);
        check("R4 still loading", {31'd0, rdy}, 0);
        wr(wa(3, 3), 32'hF0F0_F0F0);
        model[12] &= 32'h1234_5678; model[13] &= 32'hFFFF_0000;
        model[14] &= 32'h00FF_FF00; model[15] &= 32'hF0F0_F0F0;
        wait_rdy(n);
        check("R4 R6 duration after ignored words", n, PC);
        verify_all("R4 only in-order words stored");

        // R2: mismatched unlock aborts
        wr(KA, 32'hAA); wr(KB, 32'h56); wr(KA, 32'hA0);
        check("R2 abort keeps read mode", {31'd0, rdy}, 1);
        for (int w = 0; w < PW; w++) wr(wa(5, w), 32'h0);
        check("R2 no program after abort", {31'd0, rdy}, 1);
        verify_all("R2 array unchanged");

        // R12: 0xF0 aborts during unlock, is data during page entry
        wr(KA, 32'hAA); wr(KB, 32'h55); wr(KA, 32'hF0);
        check("R12 abort code returns read mode", {31'd0, rdy}, 1);
        do_reset();
        prog_page(6, -1, 1);
        rd(wa(6, 0), d);
        check("R12 abort code stored as data", d, 32'hF0);

        // R8: protected block sweep
        for (int b = 0; b < NB; b++) begin
            prot = NB'(1 << b);
            prog_page(b * PPB + 1, 3, 1);
        end
        prot = '0;
        verify_all("R8 protected blocks unchanged");

        // R9 R10: erase under every protection pattern
        for (int m = 0; m < (1 << NB); m++) begin
            for (int b = 0; b < NB; b++) prog_page(b * PPB, 4 + m, 0);
            prot = NB'(m);
            erase_all();
            prot = '0;
            verify_all((m == (1 << NB) - 1) ? "R10 all protected unchanged" : "R9 erase result");
        end

        // R7: program sequence issued during erase is ignored
        prog_page(0, 9, 0);
        unlock_erase();
        unlock_prog();
        for (int w = 0; w < PW; w++) wr(wa(0, w), 32'h0);
        wait_rdy(n);
        model_reset();
        verify_all("R7 commands ignored while erasing");
        check("R7 back in read mode", {31'd0, rdy}, 1);

        // R11: program failure lockout
        unlock_prog();
        fault_inj = 1;
        for (int w = 0; w < PW; w++) wr(wa(1, w), 32'h0);
        repeat (PC + 2) @(negedge clk);
        check("R11 locked after program fault", {31'd0, locked}, 1);
        check("R11 not ready when locked", {31'd0, rdy}, 0);
        fault_inj = 0;
        unlock_prog();
        for (int w = 0; w < PW; w++) wr(wa(1, w), 32'h0);
        repeat (PC + 2) @(negedge clk);
        check("R11 lockout holds", {31'd0, locked}, 1);
        rd(0, d);
        check("R11 R3 status while locked", d, 32'h2);
        do_reset();
        check("R11 reset clears lockout", {30'd0, locked, rdy}, 32'h1);
        verify_all("R11 array after reset");

        // R11: erase failure lockout
        prog_page(2, 5, 1);
        fault_inj = 1;
        unlock_erase();
        repeat (EC + 2) @(negedge clk);
        check("R11 locked after erase fault", {30'd0, locked, rdy}, 32'h2);
        do_reset();
        check("R1 ready after second reset", {30'd0, locked, rdy}, 32'h1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule